// File: doc/BRIEF.md
# SPDIF Channel-Status and Validity Controller

This block keeps one 16-bit control word for an SPDIF transmitter. It supplies the status side of each subframe to an external subframe formatter: the validity flag and the channel-status bit. The control word sets the professional or consumer flag, the non-PCM flag, copyright, pre-emphasis, category code, generation level and transmit rate. It also holds a validity control bit. Software writes and reads the word through a plain register port. While the transmitter is enabled, every field except the validity control is locked.

The formatter takes status bits as a stream. `bit_valid` is high whenever the transmitter is enabled. The formatter raises `bit_ready` when it consumes the bits for the current subframe. Positions run left then right within a frame, and frames run 0 to 191 within a block. If `bit_ready` stays low, the position holds and the outputs keep describing the same subframe, so back-pressure can last any number of cycles. When the transmitter is disabled, the position returns to frame 0, left subframe. The status block is then rebuilt from the register value that is current when transmission starts.

The validity output follows a fixed priority. Forced invalid comes first, then forced valid, then the per-sample error flag.

Top module: `spdif_cstat_ctrl`

## Requirements
- R1: During and right after reset, `reg_rd_data` reads 0x2000 (rate select 2'b10, meaning 48 kHz), `blk_start` is 1 and `bit_side` is 0.
- R2: A write while `tx_enable` is 0 stores all bits of `reg_wr_data`, except bit 14, which always reads back as 0.
- R3: A write while `tx_enable` is 1 changes only bit 15, the validity control. Bits 13..0 keep their previous value.
- R4: With bit 15 = 1, `v_bit` is 1 whatever `force_valid` and `sample_error` are.
- R5: With bit 15 = 0 and `force_valid` = 1, `v_bit` is 0 whatever `sample_error` is.
- R6: With bit 15 = 0 and `force_valid` = 0, `v_bit` equals `sample_error`.
- R7: `bit_valid` equals `tx_enable`. On a cycle with `bit_valid` and `bit_ready` both high, the position advances from left (`bit_side` 0) to right (1), or from right to the left side of the next frame. Without the handshake it holds. Both subframes of a frame carry the same `cs_bit`.
- R8: Frames count 0 to 191 and wrap back to 0. `blk_start` is 1 exactly on frame 0.
- R9: The `cs_bit` of frames 0, 1, 2 and 3 equals register bits 0 (professional), 1 (non-PCM), 2 (copyright) and 3 (pre-emphasis).
- R10: The `cs_bit` of frames 8 to 14 equals category bits 4 to 10 of the register in that order, and frame 15 carries register bit 11 (generation).
- R11: Frames 24 to 27 carry a 4-bit rate code, with frame 24 as its LSB. Rate select 00 (44.1 kHz) gives 0000. Every other select value, including reserved 01 and unsupported 11, gives the 48 kHz code 0010, which sets only frame 25. All frames not named in R9 to R11 carry 0.
- R12: While `tx_enable` is 0, the position is forced to frame 0, left side. The block sent after enabling reflects the register contents as they stand when transmission starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_data | output | 16 | Register read-back |
| tx_enable | input | 1 | Transmitter enabled |
| force_valid | input | 1 | Force validity to 0 when bit 15 is 0 |
| sample_error | input | 1 | Error flag of the current sample |
| bit_valid | output | 1 | Status bits available (equals tx_enable) |
| bit_ready | input | 1 | Formatter consumes the current subframe's bits |
| cs_bit | output | 1 | Channel-status bit of the current frame |
| v_bit | output | 1 | Validity bit of the current subframe |
| bit_side | output | 1 | 0 left subframe, 1 right subframe |
| blk_start | output | 1 | Current frame is frame 0 of the block |

## Verification
The bench writes random control words in which the rate select cycles through all four codes. It then runs each block past its wrap with `bit_ready` toggled at random, which separates correct hold-under-back-pressure from free-running positions. The three validity inputs are randomized independently, so every branch of the priority rule is taken with the other inputs both high and low. Random writes while enabled, including writes in the enabling cycle itself, show whether the lock on bits 13..0 holds while bit 15 still changes. Directed all-ones writes and the reserved and unsupported rate codes pin down the bit-14 read-back and the rate fallback.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;

  localparam int CTL_W = 16;

  typedef struct packed {
    logic       vctl;
    logic       rsvd;
    logic [1:0] rate;
    logic       gen;
    logic [6:0] cat;
    logic       pre;
    logic       copy;
    logic       nonpcm;
    logic       pro;
  } ctl_reg_t;

  localparam logic [CTL_W-1:0] CTL_RESET = 16'h2000;

  localparam logic [1:0] RATE_44K1 = 2'b00;
  localparam logic [3:0] CODE_44K1 = 4'b0000;
  localparam logic [3:0] CODE_48K  = 4'b0010;

  // Status block positions
  localparam int POS_PRO    = 0;
  localparam int POS_NONPCM = 1;
  localparam int POS_COPY   = 2;
  localparam int POS_PRE    = 3;
  localparam int POS_CAT    = 8;
  localparam int POS_GEN    = 15;
  localparam int POS_RATE   = 24;

  function automatic logic [3:0] rate_code(input logic [1:0] sel);
    return (sel == RATE_44K1) ? CODE_44K1 : CODE_48K;
  endfunction

endpackage

// File: rtl/spdif_ctl_reg.sv
module spdif_ctl_reg
  import spdif_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             tx_enable,
  output ctl_reg_t         ctl_q,
  output ctl_reg_t         snap_q
);

  ctl_reg_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      if (!tx_enable) begin
        ctl_d      = ctl_reg_t'(wr_data);
        ctl_d.rsvd = 1'b0;
      end else begin
        ctl_d.vctl = wr_data[CTL_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= ctl_reg_t'(CTL_RESET);
      snap_q <= ctl_reg_t'(CTL_RESET);
    end else begin
      ctl_q <= ctl_d;
      // Snapshot tracks the next value while idle, freezes once enabled
      if (!tx_enable) snap_q <= ctl_d;
    end
  end

endmodule

// File: rtl/spdif_frame_pos.sv
module spdif_frame_pos #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          advance,
  output logic [FW-1:0] frame_idx,
  output logic          right_sub
);

  localparam logic [FW-1:0] LAST = FW'(FRAMES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_idx <= '0;
      right_sub <= 1'b0;
    end else if (!run) begin
      frame_idx <= '0;
      right_sub <= 1'b0;
    end else if (advance) begin
      right_sub <= ~right_sub;
      if (right_sub) frame_idx <= (frame_idx == LAST) ? '0 : frame_idx + 1'b1;
    end
  end

endmodule

// File: rtl/spdif_cs_mux.sv
module spdif_cs_mux
  import spdif_cs_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  ctl_reg_t      snap,
  input  logic [FW-1:0] frame_idx,
  input  logic          vctl,
  input  logic          force_valid,
  input  logic          sample_error,
  output logic          cs_bit,
  output logic          v_bit
);

  logic [FRAMES-1:0] blk;

  always_comb begin
    blk = '0;
    blk[POS_PRO]    = snap.pro;
    blk[POS_NONPCM] = snap.nonpcm;
    blk[POS_COPY]   = snap.copy;
    blk[POS_PRE]    = snap.pre;
    blk[POS_CAT +: 7]  = snap.cat;
    blk[POS_GEN]    = snap.gen;
    blk[POS_RATE +: 4] = rate_code(snap.rate);
  end

  assign cs_bit = blk[frame_idx];

  always_comb begin
    if (vctl)             v_bit = 1'b1;
    else if (force_valid) v_bit = 1'b0;
    else                  v_bit = sample_error;
  end

endmodule

// File: rtl/spdif_cstat_ctrl.sv
module spdif_cstat_ctrl
  import spdif_cs_pkg::*;
#(
  parameter int FRAMES = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [15:0] reg_wr_data,
  output logic [15:0] reg_rd_data,
  input  logic        tx_enable,
  input  logic        force_valid,
  input  logic        sample_error,
  output logic        bit_valid,
  input  logic        bit_ready,
  output logic        cs_bit,
  output logic        v_bit,
  output logic        bit_side,
  output logic        blk_start
);

  localparam int FW = $clog2(FRAMES);

  ctl_reg_t      ctl_q;
  ctl_reg_t      snap_q;
  logic [FW-1:0] frm_idx;

  spdif_ctl_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_data   (reg_wr_data),
    .tx_enable (tx_enable),
    .ctl_q     (ctl_q),
    .snap_q    (snap_q)
  );

  spdif_frame_pos #(.FRAMES(FRAMES)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tx_enable),
    .advance   (bit_ready),
    .frame_idx (frm_idx),
    .right_sub (bit_side)
  );

  spdif_cs_mux #(.FRAMES(FRAMES)) u_mux (
    .snap         (snap_q),
    .frame_idx    (frm_idx),
    .vctl         (ctl_q.vctl),
    .force_valid  (force_valid),
    .sample_error (sample_error),
    .cs_bit       (cs_bit),
    .v_bit        (v_bit)
  );

  assign reg_rd_data = ctl_q;
  assign bit_valid   = tx_enable;
  assign blk_start   = (frm_idx == '0);

endmodule

// File: rtl/spdif_cstat_chk.sv
module spdif_cstat_chk #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_enable,
  input logic          bit_ready,
  input logic          force_valid,
  input logic          sample_error,
  input logic [15:0]   rd_data,
  input logic          v_bit,
  input logic          bit_side,
  input logic          blk_start,
  input logic [FW-1:0] frame_idx
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[14] == 1'b0); // R2
  AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable |=> rd_data[13:0] == $past(rd_data[13:0])); // R3
  AST_FORCE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] |-> v_bit); // R4
  AST_FORCE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[15] && force_valid) |-> !v_bit); // R5
  AST_ERROR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[15] && !force_valid) |-> (v_bit == sample_error)); // R6
  AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable && !bit_ready) |=> (!tx_enable || (bit_side == $past(bit_side) && frame_idx == $past(frame_idx)))); // R7
  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame_idx) < FRAMES); // R8
  AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable && bit_ready && bit_side && int'(frame_idx) == FRAMES - 1) |=> (blk_start && !bit_side)); // R8
  AST_IDLE_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> (blk_start && !bit_side)); // R12

endmodule

bind spdif_cstat_ctrl spdif_cstat_chk #(.FRAMES(FRAMES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_enable    (tx_enable),
  .bit_ready    (bit_ready),
  .force_valid  (force_valid),
  .sample_error (sample_error),
  .rd_data      (reg_rd_data),
  .v_bit        (v_bit),
  .bit_side     (bit_side),
  .blk_start    (blk_start),
  .frame_idx    (frm_idx)
);

// File: tb/spdif_cstat_ctrl_tb.sv
module spdif_cstat_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NFR = 192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic        tx_enable = 1'b0;
  logic        force_valid = 1'b0;
  logic        sample_error = 1'b0;
  logic        bit_valid;
  logic        bit_ready = 1'b0;
  logic        cs_bit;
  logic        v_bit;
  logic        bit_side;
  logic        blk_start;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_reg;
  int          m_frame;
  bit          m_right;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdif_cstat_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .tx_enable(tx_enable), .force_valid(force_valid),
    .sample_error(sample_error), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .cs_bit(cs_bit), .v_bit(v_bit), .bit_side(bit_side), .blk_start(blk_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_cs(input logic [15:0] r, input int f);
    logic [3:0] rc;
    rc = (r[13:12] == 2'b00) ? 4'b0000 : 4'b0010;
    if (f <= 3) return r[f];
    if (f >= 8 && f <= 14) return r[f - 4];
    if (f == 15) return r[11];
    if (f >= 24 && f <= 27) return rc[f - 24];
    return 1'b0;
  endfunction

  function automatic string cs_tag(input int f);
    if (f <= 3) return "R9";
    if (f >= 8 && f <= 15) return "R10";
    return "R11";
  endfunction

  function automatic bit exp_v(input logic [15:0] r, input bit fv, input bit er);
    if (r[15]) return 1'b1;
    if (fv) return 1'b0;
    return er;
  endfunction

  // Drive after an edge, check mid-cycle, update model at the next edge
  task automatic cycle(input bit we, input logic [15:0] d, input bit txe,
                       input bit rdy, input bit fv, input bit er);
    string vt;
    reg_wr_en = we; reg_wr_data = d; tx_enable = txe;
    bit_ready = rdy; force_valid = fv; sample_error = er;
    #(CLK_PERIOD/2 - 1);
    vt = m_reg[15] ? "R4" : (fv ? "R5" : "R6");
    chk(bit_valid == txe, "R7", bit_valid, txe);
    chk(reg_rd_data == m_reg, txe ? "R3" : "R2", reg_rd_data, m_reg);
    chk(v_bit == exp_v(m_reg, fv, er), vt, v_bit, exp_v(m_reg, fv, er));
    chk(cs_bit == exp_cs(m_reg, m_frame), cs_tag(m_frame), cs_bit, exp_cs(m_reg, m_frame));
    chk(blk_start == (m_frame == 0), "R8", blk_start, m_frame == 0);
    chk(bit_side == m_right, "R7", bit_side, m_right);
    @(posedge clk);
    if (we) begin
      if (!txe) m_reg = {d[15], 1'b0, d[13:0]};
      else      m_reg[15] = d[15];
    end
    if (!txe) begin
      m_frame = 0; m_right = 1'b0;
    end else if (rdy) begin
      if (m_right) m_frame = (m_frame == NFR - 1) ? 0 : m_frame + 1;
      m_right = ~m_right;
    end
    #1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_reg = 16'h2000; m_frame = 0; m_right = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(reg_rd_data == 16'h2000, "R1", reg_rd_data, 16'h2000);
    chk(blk_start == 1'b1, "R1", blk_start, 1);
    chk(bit_side == 1'b0, "R1", bit_side, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(reg_rd_data == 16'h2000, "R1", reg_rd_data, 16'h2000);

    // Directed: all-ones write, bit 14 reads 0 (R2); rate 11 falls back (R11)
    cycle(1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle(1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1);
    // Enable, then try to clear everything while enabled (R3)
    cycle(1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    cycle(1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1);
    cycle(1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    cycle(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);

    // Random blocks, rate select cycling through all four codes (R7-R12)
    for (int k = 0; k < 12; k++) begin
      logic [15:0] w;
      w = 16'($urandom());
      w[13:12] = 2'(k % 4);
      cycle(1'b1, w, 1'b0, 1'($urandom() % 2), 1'($urandom() % 2), 1'($urandom() % 2));
      cycle(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
      for (int c = 0; c < 1000; c++) begin
        bit we;
        we = ($urandom() % 20) == 0;
        cycle(we, 16'($urandom()), 1'b1, ($urandom() % 10) < 7,
              1'($urandom() % 2), 1'($urandom() % 2));
      end
      // Disable mid-block: position returns to frame 0 left (R12)
      cycle(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
      cycle(1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule